// File: doc/BRIEF.md
# Wavefront Instruction Fetch Arbiter

This block decides which wavefront of a compute unit receives the next instruction-fetch slot. The unit holds a grid of wavent slots, several SIMD lanes each owning a fixed number of wavefront slots. Every slot keeps its own program counter, a scheduling priority fixed at launch, an age counter, and a count of the instructions held in its instruction buffer. In every cycle the arbiter looks at all slots that could take one more fetch return and offers a single request: the slot number and its current fetch address.

The request is ranked by a composite key rather than a rotating pointer. A higher scheduling priority wins first. Among equal priorities, the slot with fewer buffered instructions wins. After that, the older wavefront wins, and any remaining tie goes to the lowest slot number. When the cache side accepts the request, the slot's PC steps forward by one fetch block and the slot waits for the data. A redirect port loads a new PC, empties the buffer count and cancels any fetch still in flight. Data returned for a cancelled fetch is then dropped.

Each slot runs a four-state machine. The states are EMPTY, ACTIVE, PENDING and FLUSH. The named transitions are: LAUNCH (EMPTY to ACTIVE), GRANT (ACTIVE to PENDING), RETURN (PENDING to ACTIVE, adding a fetch block to the count), CANCEL (a redirect while PENDING, or together with a GRANT, moves the slot to FLUSH), STALE_RETURN (FLUSH to ACTIVE with nothing added), REDIRECT (ACTIVE to ACTIVE with a new PC) and RETIRE (any state to EMPTY).

Top module: `wf_fetch_arb`

## Requirements
- R1: After reset every slot is EMPTY and `fetch_valid` is 0.
- R2: A slot may be offered only in the ACTIVE state and only when its buffered count plus FETCH_BYTES/INSTR_BYTES instructions does not exceed BUF_DEPTH.
- R3: Among eligible slots, the one with the numerically larger scheduling priority is offered.
- R4: When priorities are equal, the slot with the smaller buffered-instruction count is offered.
- R5: When priority and count are equal, the slot with the larger age is offered. Age is 0 in the cycle after launch, rises by one each cycle while the slot is not EMPTY, and saturates at 2^AGE_W-1.
- R6: Any remaining tie goes to the lowest flat slot number, where the number is simd*WAVES_PER_SIMD+wave.
- R7: `fetch_addr` is the offered slot's PC. When `fetch_valid` and `fetch_ready` are both high, the PC grows by FETCH_BYTES and the slot enters PENDING, in which it is not offered.
- R8: A return to a PENDING slot adds FETCH_BYTES/INSTR_BYTES to its count and makes it ACTIVE. A consume subtracts one unless the count is 0. Both may occur in the same cycle.
- R9: A redirect sets the PC and clears the count. If a fetch is PENDING, or is accepted in the same cycle, the slot enters FLUSH and is not offered. The next return to that slot adds nothing and makes it ACTIVE.
- R10: A launch to a non-EMPTY slot is ignored. A retire makes the slot EMPTY and takes precedence over a launch. A return to a slot that is neither PENDING nor FLUSH is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Start a wavefront in slot `launch_id` |
| launch_id | input | IDW | Flat slot number for the launch |
| launch_prio | input | PRIO_W | Scheduling priority of the new wavefront |
| launch_pc | input | PC_W | Start PC |
| retire_valid | input | 1 | Free slot `retire_id` |
| retire_id | input | IDW | Slot to free |
| redirect_valid | input | 1 | Load a new PC into slot `redirect_id` |
| redirect_id | input | IDW | Slot to redirect |
| redirect_pc | input | PC_W | New PC |
| ret_valid | input | 1 | Fetch data arrived for slot `ret_id` |
| ret_id | input | IDW | Slot receiving data |
| consume_valid | input | 1 | One instruction taken from slot `consume_id` |
| consume_id | input | IDW | Slot being drained |
| fetch_ready | input | 1 | Cache side accepts the offered request |
| fetch_valid | output | 1 | A request is offered |
| fetch_id | output | IDW | Offered slot number |
| fetch_addr | output | PC_W | Offered fetch address |

## Verification
A redirect and the acceptance of a fetch can hit the same slot in one cycle. The new PC must win over the step. The slot must also remember that a now-stale return is coming. The bench provokes this by raising `fetch_ready` while redirecting the slot that is being offered. It then sends a return for that slot, and a reference model built from the requirements judges each cycle's offer. The slot must stay out of arbitration until the return arrives, must come back with an empty count, and its first offer must carry the redirected address.

// File: rtl/wf_fetch_pkg.sv
package wf_fetch_pkg;

    typedef enum logic [1:0] {
        WS_EMPTY   = 2'd0,
        WS_ACTIVE  = 2'd1,
        WS_PENDING = 2'd2,
        WS_FLUSH   = 2'd3
    } wave_state_e;

endpackage

// File: rtl/wf_slot.sv
module wf_slot
    import wf_fetch_pkg::*;
#(
    parameter int PC_W        = 40,
    parameter int PRIO_W      = 2,
    parameter int AGE_W       = 6,
    parameter int BUF_DEPTH   = 16,
    parameter int FETCH_INSTR = 4,
    parameter int FETCH_BYTES = 32,
    localparam int OCC_W      = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_hit,
    input  logic [PRIO_W-1:0] launch_prio,
    input  logic [PC_W-1:0]   launch_pc,
    input  logic              retire_hit,
    input  logic              redirect_hit,
    input  logic [PC_W-1:0]   redirect_pc,
    input  logic              ret_hit,
    input  logic              consume_hit,
    input  logic              grant_hit,
    output logic              eligible,
    output logic [PC_W-1:0]   pc,
    output logic [PRIO_W-1:0] prio,
    output logic [AGE_W-1:0]  age,
    output logic [OCC_W-1:0]  occ
);

    localparam logic [AGE_W-1:0] AGE_MAX   = '1;
    localparam logic [OCC_W-1:0] OCC_ROOM  = OCC_W'(BUF_DEPTH - FETCH_INSTR);
    localparam logic [OCC_W-1:0] OCC_BLOCK = OCC_W'(FETCH_INSTR);
    localparam logic [PC_W-1:0]  PC_STEP   = PC_W'(FETCH_BYTES);

    wave_state_e st, st_nx;
    logic [PC_W-1:0]   pc_nx;
    logic [OCC_W-1:0]  occ_nx, occ_drain;
    logic [AGE_W-1:0]  age_nx;
    logic [PRIO_W-1:0] prio_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= WS_EMPTY;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (retire_hit) begin
            st_nx = WS_EMPTY;                                   // RETIRE
        end else begin
            unique case (st)
                WS_EMPTY:   if (launch_hit) st_nx = WS_ACTIVE;  // LAUNCH
                WS_ACTIVE: begin
                    if (grant_hit && redirect_hit) st_nx = WS_FLUSH;    // CANCEL
                    else if (grant_hit)            st_nx = WS_PENDING;  // GRANT
                end
                WS_PENDING: begin
                    if (ret_hit)           st_nx = WS_ACTIVE;   // RETURN
                    else if (redirect_hit) st_nx = WS_FLUSH;    // CANCEL
                end
                WS_FLUSH:   if (ret_hit) st_nx = WS_ACTIVE;     // STALE_RETURN
                default:    st_nx = WS_EMPTY;
            endcase
        end
    end

    // datapath next values
    always_comb begin
        occ_drain = (consume_hit && occ != '0) ? occ - 1'b1 : occ;
        pc_nx     = pc;
        occ_nx    = occ;
        prio_nx   = prio;
        age_nx    = (age == AGE_MAX) ? age : age + 1'b1;
        if (st == WS_EMPTY) begin
            age_nx = age;
            if (launch_hit) begin
                pc_nx   = launch_pc;
                prio_nx = launch_prio;
                occ_nx  = '0;
                age_nx  = '0;
            end
        end else begin
            if (redirect_hit)   pc_nx = redirect_pc;
            else if (grant_hit) pc_nx = pc + PC_STEP;
            if (redirect_hit)
                occ_nx = '0;
            else if (ret_hit && st == WS_PENDING)
                occ_nx = occ_drain + OCC_BLOCK;
            else
                occ_nx = occ_drain;
        end
    end

    // output / datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc   <= '0;
            occ  <= '0;
            age  <= '0;
            prio <= '0;
        end else if (!retire_hit) begin
            pc   <= pc_nx;
            occ  <= occ_nx;
            age  <= age_nx;
            prio <= prio_nx;
        end
    end

    assign eligible = (st == WS_ACTIVE) && (occ <= OCC_ROOM);

    // R7: an accepted fetch steps the PC by one block
    a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_ACTIVE && grant_hit && !redirect_hit && !retire_hit)
        |=> (pc == $past(pc) + PC_STEP));

    // R7: a waiting slot is never granted again
    a_r7_no_double_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_PENDING || st == WS_FLUSH) |-> !grant_hit);

    // R8: buffer count never exceeds its depth
    a_r8_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(BUF_DEPTH));

    // R9: a stale return adds nothing
    a_r9_stale_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_FLUSH && ret_hit && !redirect_hit && !retire_hit && !consume_hit)
        |=> (occ == $past(occ)));

    // R5: saturated age stays saturated
    a_r5_age_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st != WS_EMPTY && !retire_hit && age == AGE_MAX) |=> (age == AGE_MAX));

    // R10: launch into a busy slot leaves priority untouched
    a_r10_launch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st != WS_EMPTY && launch_hit && !retire_hit) |=> (prio == $past(prio)));

endmodule

// File: rtl/wf_pick.sv
module wf_pick #(
    parameter int N      = 40,
    parameter int IDW    = 6,
    parameter int PRIO_W = 2,
    parameter int OCC_W  = 5,
    parameter int AGE_W  = 6,
    localparam int KEY_W = PRIO_W + OCC_W + AGE_W
) (
    input  logic [N-1:0]      elig,
    input  logic [PRIO_W-1:0] prio [N],
    input  logic [OCC_W-1:0]  occ  [N],
    input  logic [AGE_W-1:0]  age  [N],
    output logic              pick_valid,
    output logic [IDW-1:0]    pick_id
);

    logic [KEY_W-1:0] best_key;
    logic [KEY_W-1:0] cand_key;

    // strict comparison keeps the lowest index on ties
    always_comb begin
        pick_valid = 1'b0;
        pick_id    = '0;
        best_key   = '0;
        cand_key   = '0;
        for (int i = 0; i < N; i++) begin
            cand_key = {prio[i], ~occ[i], age[i]};
            if (elig[i] && (!pick_valid || cand_key > best_key)) begin
                pick_valid = 1'b1;
                pick_id    = IDW'(i);
                best_key   = cand_key;
            end
        end
    end

endmodule

// File: rtl/wf_fetch_arb.sv
module wf_fetch_arb
    import wf_fetch_pkg::*;
#(
    parameter int NUM_SIMD       = 4,
    parameter int WAVES_PER_SIMD = 10,
    parameter int PC_W           = 40,
    parameter int PRIO_W         = 2,
    parameter int AGE_W          = 6,
    parameter int BUF_DEPTH      = 16,
    parameter int FETCH_BYTES    = 32,
    parameter int INSTR_BYTES    = 8,
    localparam int NSLOT         = NUM_SIMD * WAVES_PER_SIMD,
    localparam int IDW           = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_valid,
    input  logic [IDW-1:0]    launch_id,
    input  logic [PRIO_W-1:0] launch_prio,
    input  logic [PC_W-1:0]   launch_pc,
    input  logic              retire_valid,
    input  logic [IDW-1:0]    retire_id,
    input  logic              redirect_valid,
    input  logic [IDW-1:0]    redirect_id,
    input  logic [PC_W-1:0]   redirect_pc,
    input  logic              ret_valid,
    input  logic [IDW-1:0]    ret_id,
    input  logic              consume_valid,
    input  logic [IDW-1:0]    consume_id,
    input  logic              fetch_ready,
    output logic              fetch_valid,
    output logic [IDW-1:0]    fetch_id,
    output logic [PC_W-1:0]   fetch_addr
);

    localparam int FETCH_INSTR = FETCH_BYTES / INSTR_BYTES;
    localparam int OCC_W       = $clog2(BUF_DEPTH + 1);

    logic [NSLOT-1:0]  elig_vec;
    logic [NSLOT-1:0]  grant_vec;
    logic [PC_W-1:0]   pc_arr   [NSLOT];
    logic [PRIO_W-1:0] prio_arr [NSLOT];
    logic [AGE_W-1:0]  age_arr  [NSLOT];
    logic [OCC_W-1:0]  occ_arr  [NSLOT];
    logic              accept;

    assign accept = fetch_valid && fetch_ready;

    for (genvar s = 0; s < NUM_SIMD; s++) begin : g_simd
        for (genvar w = 0; w < WAVES_PER_SIMD; w++) begin : g_wave
            localparam int K = s * WAVES_PER_SIMD + w;
            assign grant_vec[K] = accept && (fetch_id == IDW'(K));
            wf_slot #(
                .PC_W        (PC_W),
                .PRIO_W      (PRIO_W),
                .AGE_W       (AGE_W),
                .BUF_DEPTH   (BUF_DEPTH),
                .FETCH_INSTR (FETCH_INSTR),
                .FETCH_BYTES (FETCH_BYTES)
            ) u_slot (
                .clk          (clk),
                .rst_n        (rst_n),
                .launch_hit   (launch_valid && launch_id == IDW'(K)),
                .launch_prio  (launch_prio),
                .launch_pc    (launch_pc),
                .retire_hit   (retire_valid && retire_id == IDW'(K)),
                .redirect_hit (redirect_valid && redirect_id == IDW'(K)),
                .redirect_pc  (redirect_pc),
                .ret_hit      (ret_valid && ret_id == IDW'(K)),
                .consume_hit  (consume_valid && consume_id == IDW'(K)),
                .grant_hit    (grant_vec[K]),
                .eligible     (elig_vec[K]),
                .pc           (pc_arr[K]),
                .prio         (prio_arr[K]),
                .age          (age_arr[K]),
                .occ          (occ_arr[K])
            );
        end
    end

    wf_pick #(
        .N      (NSLOT),
        .IDW    (IDW),
        .PRIO_W (PRIO_W),
        .OCC_W  (OCC_W),
        .AGE_W  (AGE_W)
    ) u_pick (
        .elig       (elig_vec),
        .prio       (prio_arr),
        .occ        (occ_arr),
        .age        (age_arr),
        .pick_valid (fetch_valid),
        .pick_id    (fetch_id)
    );

    always_comb begin
        fetch_addr = '0;
        for (int i = 0; i < NSLOT; i++)
            if (fetch_id == IDW'(i)) fetch_addr = pc_arr[i];
    end

    // R2: the offered slot is one the slots report as eligible
    a_r2_offer_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> |(elig_vec & (NSLOT'(1) << fetch_id)));

    // R2: any eligible slot means an offer is made
    a_r2_offer_when_any: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_vec != '0) |-> fetch_valid);

    // R7: at most one slot granted per cycle
    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

endmodule

// File: tb/wf_fetch_arb_bench.sv
`timescale 1ns/100ps
module wf_fetch_arb_bench;

    localparam int NS = 2, WPS = 4, N = 8, IDW = 3, PCW = 40, PW = 2, AW = 3;
    localparam int DEPTH = 8, FB = 32, FI = 4, AMAX = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic launch_valid = 0, retire_valid = 0, redirect_valid = 0, ret_valid = 0, consume_valid = 0;
    logic fetch_ready = 0;
    logic [IDW-1:0] launch_id = 0, retire_id = 0, redirect_id = 0, ret_id = 0, consume_id = 0;
    logic [PW-1:0]  launch_prio = 0;
    logic [PCW-1:0] launch_pc = 0, redirect_pc = 0;
    logic fetch_valid;
    logic [IDW-1:0] fetch_id;
    logic [PCW-1:0] fetch_addr;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    int m_st [N];   // 0 empty, 1 active, 2 pending, 3 flush
    logic [PCW-1:0] m_pc [N];
    int m_occ [N], m_age [N], m_prio [N];

    always #2.5 clk = ~clk;

    wf_fetch_arb #(
        .NUM_SIMD(NS), .WAVES_PER_SIMD(WPS), .PC_W(PCW), .PRIO_W(PW),
        .AGE_W(AW), .BUF_DEPTH(DEPTH), .FETCH_BYTES(FB), .INSTR_BYTES(8)
    ) u_wf_fetch_arb (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_id(launch_id), .launch_prio(launch_prio), .launch_pc(launch_pc),
        .retire_valid(retire_valid), .retire_id(retire_id),
        .redirect_valid(redirect_valid), .redirect_id(redirect_id), .redirect_pc(redirect_pc),
        .ret_valid(ret_valid), .ret_id(ret_id),
        .consume_valid(consume_valid), .consume_id(consume_id),
        .fetch_ready(fetch_ready), .fetch_valid(fetch_valid), .fetch_id(fetch_id), .fetch_addr(fetch_addr)
    );

    // R2..R6: expected offer from the model
    function automatic void predict(output bit v, output int id);
        v = 0; id = 0;
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 1 && m_occ[i] + FI <= DEPTH) begin
                if (!v || m_prio[i] > m_prio[id] ||
                    (m_prio[i] == m_prio[id] && (m_occ[i] < m_occ[id] ||
                     (m_occ[i] == m_occ[id] && m_age[i] > m_age[id])))) begin
                    v = 1; id = i;
                end
            end
        end
    endfunction

    function automatic void model_clock(bit ev, int eid);
        for (int i = 0; i < N; i++) begin
            bit acc, rl, rt, cs;
            acc = fetch_ready && ev && eid == i;
            rl  = redirect_valid && redirect_id == IDW'(i);
            rt  = ret_valid && ret_id == IDW'(i);
            cs  = consume_valid && consume_id == IDW'(i);
            if (retire_valid && retire_id == IDW'(i)) begin
                m_st[i] = 0;
            end else if (m_st[i] == 0) begin
                if (launch_valid && launch_id == IDW'(i)) begin
                    m_st[i] = 1; m_pc[i] = launch_pc; m_occ[i] = 0;
                    m_age[i] = 0; m_prio[i] = int'(launch_prio);
                end
            end else begin
                int o;
                o = m_occ[i];
                if (cs && o > 0) o = o - 1;
                if (rl) o = 0;
                else if (rt && m_st[i] == 2) o = o + FI;
                if (m_age[i] < AMAX) m_age[i] = m_age[i] + 1;
                if (rl) m_pc[i] = redirect_pc;
                else if (acc) m_pc[i] = m_pc[i] + FB;
                case (m_st[i])
                    1: if (acc && rl) m_st[i] = 3; else if (acc) m_st[i] = 2;
                    2: if (rt) m_st[i] = 1; else if (rl) m_st[i] = 3;
                    3: if (rt) m_st[i] = 1;
                    default: ;
                endcase
                m_occ[i] = o;
            end
        end
    endfunction

    task automatic step(input string tag);
        bit ev; int eid;
        #1;
        predict(ev, eid);
        n_tests++;
        if (fetch_valid !== ev) begin
            n_fail++;
            $display("FAIL %s: fetch_valid=%0b expected %0b", tag, fetch_valid, ev);
        end
        if (ev) begin
            n_tests++;
            if (fetch_id !== IDW'(eid)) begin
                n_fail++;
                $display("FAIL %s: fetch_id=%0d expected %0d", tag, fetch_id, eid);
            end
            n_tests++;
            if (fetch_addr !== m_pc[eid]) begin
                n_fail++;
                $display("FAIL %s: fetch_addr=%h expected %h", tag, fetch_addr, m_pc[eid]);
            end
        end
        @(posedge clk);
        model_clock(ev, eid);
        @(negedge clk);
        launch_valid = 0; retire_valid = 0; redirect_valid = 0; ret_valid = 0; consume_valid = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL R1: watchdog finished=0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_pc[i] = 0; m_occ[i] = 0; m_age[i] = 0; m_prio[i] = 0;
        end
        repeat (3) @(negedge clk);
        n_tests++;
        if (fetch_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: fetch_valid=%0b expected 0 in reset", fetch_valid);
        end
        rst_n = 1'b1;
        step("R1");

        launch_valid = 1; launch_id = 2; launch_prio = 1; launch_pc = 40'h1000; step("R2");
        launch_valid = 1; launch_id = 5; launch_prio = 3; launch_pc = 40'h2000; step("R3");
        step("R3");
        launch_valid = 1; launch_id = 5; launch_prio = 0; launch_pc = 40'h9000; step("R10");
        step("R10");
        fetch_ready = 1; step("R7");
        fetch_ready = 0; step("R7");
        ret_valid = 1; ret_id = 5; step("R8");
        launch_valid = 1; launch_id = 1; launch_prio = 3; launch_pc = 40'h3000; step("R4");
        step("R4");
        launch_valid = 1; launch_id = 0; launch_prio = 3; launch_pc = 40'h4000; step("R5");
        step("R5");
        repeat (10) step("R5");
        step("R6");
        fetch_ready = 1; redirect_valid = 1; redirect_id = 0; redirect_pc = 40'h5000; step("R9");
        fetch_ready = 0; step("R9");
        ret_valid = 1; ret_id = 0; step("R9");
        step("R9");
        consume_valid = 1; consume_id = 5; step("R8");
        consume_valid = 1; consume_id = 5; ret_valid = 1; ret_id = 5; step("R8");
        retire_valid = 1; retire_id = 1; launch_valid = 1; launch_id = 1; step("R10");
        ret_valid = 1; ret_id = 1; step("R10");
        step("R10");

        for (int c = 0; c < 4000; c++) begin
            fetch_ready    = ($urandom_range(0, 3) != 0);
            launch_valid   = ($urandom_range(0, 3) == 0);
            launch_id      = IDW'($urandom_range(0, N - 1));
            launch_prio    = PW'($urandom_range(0, 3));
            launch_pc      = {8'h0, $urandom} & ~40'h7;
            retire_valid   = ($urandom_range(0, 15) == 0);
            retire_id      = IDW'($urandom_range(0, N - 1));
            redirect_valid = ($urandom_range(0, 7) == 0);
            redirect_id    = IDW'($urandom_range(0, N - 1));
            redirect_pc    = {8'h1, $urandom} & ~40'h7;
            ret_valid      = ($urandom_range(0, 1) == 0);
            ret_id         = IDW'($urandom_range(0, N - 1));
            consume_valid  = ($urandom_range(0, 1) == 0);
            consume_id     = IDW'($urandom_range(0, N - 1));
            case (c % 5)
                0: step("R2");
                1: step("R3");
                2: step("R8");
                3: step("R9");
                default: step("R5");
            endcase
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule